// File: doc/BRIEF.md
# Input Capture Edge Delay Filter

This block guards one timer input line against short glitches. The raw pin first passes through a two-flop synchronizer. Edge detection then runs on the synchronized level. When the filter is active, a detected edge starts a down-counter of programmable length. When the count expires, the block samples the level again. It issues a single-cycle qualified-edge pulse only if the line now sits at the level opposite to the one it held just before the edge.

The delay length comes from an 8-bit control register and a mode input. In coarse mode only the two lowest register bits matter and they pick one of three long delays, or no delay at all. In fine mode the whole byte is used and a value n gives (n+1)*4 bus cycles. A zero setting in either mode bypasses the filter, so every detected edge is passed straight through.

The line is expected to stay quiet between active edges for longer than the selected delay. Edges that arrive while a count is running are not acted on.

Top module: `edge_delay_filter`

## Requirements
- R1: The control register resets to 0x00. A write (`cfg_we` high at a clock edge) stores `cfg_wdata`, and the stored value is visible on `cfg_rdata` from the next cycle.
- R2: In coarse mode (`fine_mode` = 0) only register bits [1:0] select the delay: 01 gives 256 cycles, 10 gives 512 and 11 gives 1024. Bits [7:2] have no effect.
- R3: In fine mode (`fine_mode` = 1) a nonzero register value n gives a delay of (n+1)*4 cycles. For example, n=1 gives 8, n=7 gives 32 and n=255 gives 1024.
- R4: With the filter bypassed (coarse bits [1:0] = 00, or fine value 0), each change of the pin produces `qual_pulse` exactly 3 cycles after the pin changes: 2 synchronizer cycles plus 1 output register.
- R5: With a delay D selected, a qualified pulse appears 3+D cycles after the pin change. It appears only if the synchronized level at the end of the count is the inverse of the level before the edge, so a pulse shorter than D produces no output.
- R6: Edges detected while a count is running are ignored. The pre-edge level is captured when the counting edge is detected.
- R7: A register write made while a count is running does not change that count. The new setting applies from the next detected edge.
- R8: `qual_pulse` is one cycle wide and qualifies rising and falling edges alike. Each qualified edge yields exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Raw, asynchronous capture input |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| fine_mode | input | 1 | 0 = coarse delay table, 1 = fine (n+1)*4 delay |
| cfg_rdata | output | 8 | Control register read data |
| qual_pulse | output | 1 | One-cycle qualified-edge pulse |

## Verification
Several properties are checked on every cycle:
- the counter steps down by one per cycle while busy;
- a count ends one cycle after reaching zero;
- the latched pre-edge level stays fixed for the whole count;
- a bypassed edge yields a pulse with no count;
- the register comes out of reset cleared.

Other behaviours can only be shown by the bench's scenarios:
- the absolute latencies of both delay encodings;
- rejection of a short glitch;
- ignoring edges during a count;
- the deferred effect of a write made mid-count.

// File: rtl/edf_pkg.sv
package edf_pkg;

    localparam int CTRL_W = 8;
    localparam int CNT_W  = 11;

    typedef enum logic {
        MODE_COARSE = 1'b0,
        MODE_FINE   = 1'b1
    } dly_mode_e;

    typedef struct packed {
        logic             busy;
        logic             pre_lvl;
        logic [CNT_W-1:0] left;
    } qual_state_t;

    // Number of bus cycles to wait after an edge; zero means bypass.
    function automatic logic [CNT_W-1:0] delay_len(input logic [CTRL_W-1:0] code,
                                                   input dly_mode_e mode);
        logic [CNT_W-1:0] n;
        n = CNT_W'(code);
        if (mode == MODE_FINE) begin
            if (code == '0) return '0;
            return (n + 1'b1) << 2;
        end
        case (code[1:0])
            2'b01:   return CNT_W'(256);
            2'b10:   return CNT_W'(512);
            2'b11:   return CNT_W'(1024);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/edf_sync.sv
module edf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/edf_ctrl_reg.sv
module edf_ctrl_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata;
    end

    assert_reg_reset_R1: assert property (@(posedge clk) $past(rst) |-> q == '0)
        else $error("control register not cleared by reset");
endmodule

// File: rtl/edf_qualifier.sv
module edf_qualifier
    import edf_pkg::*;
#(
    parameter int LW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lvl,
    input  logic [LW-1:0] len,
    output logic          pulse
);
    logic        lvl_d;
    logic        edge_evt;
    qual_state_t st;

    assign edge_evt = lvl ^ lvl_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_d <= 1'b0;
            st    <= '0;
            pulse <= 1'b0;
        end else begin
            lvl_d <= lvl;
            pulse <= 1'b0;
            if (st.busy) begin
                if (st.left == '0) begin
                    st.busy <= 1'b0;
                    pulse   <= (lvl != st.pre_lvl);
                end else begin
                    st.left <= st.left - 1'b1;
                end
            end else if (edge_evt) begin
                if (len == '0) begin
                    pulse <= 1'b1;
                end else begin
                    st.busy    <= 1'b1;
                    st.pre_lvl <= lvl_d;
                    st.left    <= CNT_W'(len - 1'b1);
                end
            end
        end
    end

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        st.busy && st.left != '0 |=> st.busy && st.left == $past(st.left) - 1'b1)
        else $error("delay counter did not step");

    assert_count_ends_R5: assert property (@(posedge clk) disable iff (rst)
        st.busy && st.left == '0 |=> !st.busy)
        else $error("count did not finish");

    assert_level_held_R6: assert property (@(posedge clk) disable iff (rst)
        st.busy && $past(st.busy) |-> $stable(st.pre_lvl))
        else $error("pre-edge level changed during count");

    assert_bypass_direct_R4: assert property (@(posedge clk) disable iff (rst)
        !st.busy && edge_evt && len == '0 |=> pulse && !st.busy)
        else $error("bypassed edge not passed through");
endmodule

// File: rtl/edge_delay_filter.sv
module edge_delay_filter
    import edf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              fine_mode,
    output logic [CTRL_W-1:0] cfg_rdata,
    output logic              qual_pulse
);
    logic             lvl_sync;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0] len;

    edf_ctrl_reg #(.W(CTRL_W)) u_reg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .q(ctrl_q)
    );

    edf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(lvl_sync)
    );

    assign len       = delay_len(ctrl_q, dly_mode_e'(fine_mode));
    assign cfg_rdata = ctrl_q;

    edf_qualifier #(.LW(CNT_W)) u_qual (
        .clk(clk), .rst(rst), .lvl(lvl_sync), .len(len), .pulse(qual_pulse)
    );
endmodule

// File: tb/sim_edge_delay_filter.sv
`timescale 1ns/1ps
module sim_edge_delay_filter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_in = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       fine_mode = 1'b0;
    logic [7:0] cfg_rdata;
    logic       qual_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pulse_cnt = 0;
    int last_at = -1;
    int doubles = 0;
    bit prev_p = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    edge_delay_filter u0 (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .fine_mode(fine_mode),
        .cfg_rdata(cfg_rdata), .qual_pulse(qual_pulse)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (qual_pulse) begin
            pulse_cnt <= pulse_cnt + 1;
            last_at   <= cyc + 1;
            if (prev_p) doubles <= doubles + 1;
        end
        prev_p <= qual_pulse;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic write_cfg(input logic [7:0] v, input bit fine);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = v; fine_mode = fine;
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // Drive the pin to v and expect exactly one pulse 3+d cycles later.
    task automatic edge_expect(input bit v, input int d, input string req);
        int t0, pc0;
        @(negedge clk); #1;
        pin_in = v; t0 = cyc; pc0 = pulse_cnt;
        wait_cyc(3 + d + 4);
        check(pulse_cnt == pc0 + 1, req, pulse_cnt - pc0, 1);
        check(last_at - t0 == 3 + d, req, last_at - t0, 3 + d);
    endtask

    task automatic t_reset;
        check(qual_pulse == 1'b0, "R1", int'(qual_pulse), 0);
        check(cfg_rdata == 8'h00, "R1", int'(cfg_rdata), 0);
        write_cfg(8'hA5, 1'b0);
        check(cfg_rdata == 8'hA5, "R1", int'(cfg_rdata), 8'hA5);
        write_cfg(8'h00, 1'b0);
        check(cfg_rdata == 8'h00, "R1", int'(cfg_rdata), 0);
    endtask

    task automatic t_bypass;
        write_cfg(8'h00, 1'b0);
        edge_expect(1'b1, 0, "R4 coarse 00");
        write_cfg(8'hFC, 1'b0);
        edge_expect(1'b0, 0, "R4 coarse upper bits");
        write_cfg(8'h00, 1'b1);
        edge_expect(1'b1, 0, "R4 fine zero");
        edge_expect(1'b0, 0, "R4 fine zero fall");
    endtask

    task automatic t_coarse;
        write_cfg(8'h01, 1'b0);
        edge_expect(1'b1, 256, "R2 code 01");
        write_cfg(8'h02, 1'b0);
        edge_expect(1'b0, 512, "R2 code 10");
        write_cfg(8'h03, 1'b0);
        edge_expect(1'b1, 1024, "R2 code 11");
        write_cfg(8'hFD, 1'b0);
        edge_expect(1'b0, 256, "R2 upper bits ignored");
    endtask

    task automatic t_fine;
        write_cfg(8'd1, 1'b1);
        edge_expect(1'b1, 8, "R3 n=1");
        write_cfg(8'd7, 1'b1);
        edge_expect(1'b0, 32, "R3 n=7 R8 falling");
        write_cfg(8'd255, 1'b1);
        edge_expect(1'b1, 1024, "R3 n=255");
        edge_expect(1'b0, 1024, "R3 n=255 fall");
    endtask

    task automatic t_glitch;
        int pc0;
        write_cfg(8'd7, 1'b1);
        @(negedge clk); #1;
        pc0 = pulse_cnt;
        pin_in = 1'b1;
        wait_cyc(10);
        pin_in = 1'b0;
        wait_cyc(60);
        check(pulse_cnt == pc0, "R5 glitch rejected", pulse_cnt - pc0, 0);
    endtask

    task automatic t_ignore;
        int t0, pc0;
        write_cfg(8'd7, 1'b1);
        @(negedge clk); #1;
        pin_in = 1'b1; t0 = cyc; pc0 = pulse_cnt;
        wait_cyc(10);
        pin_in = 1'b0;
        wait_cyc(5);
        pin_in = 1'b1;
        wait_cyc(80);
        check(pulse_cnt == pc0 + 1, "R6 single pulse", pulse_cnt - pc0, 1);
        check(last_at - t0 == 35, "R6 latency", last_at - t0, 35);
    endtask

    task automatic t_midwrite;
        int t0, pc0;
        write_cfg(8'd7, 1'b1);
        @(negedge clk); #1;
        pin_in = 1'b0; t0 = cyc; pc0 = pulse_cnt;
        wait_cyc(10);
        cfg_we = 1'b1; cfg_wdata = 8'd1;
        wait_cyc(1);
        cfg_we = 1'b0;
        wait_cyc(40);
        check(pulse_cnt == pc0 + 1, "R7 count kept", pulse_cnt - pc0, 1);
        check(last_at - t0 == 35, "R7 old delay", last_at - t0, 35);
        edge_expect(1'b1, 8, "R7 new delay");
    endtask

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
        t_reset();
        t_bypass();
        t_coarse();
        t_fine();
        t_glitch();
        t_ignore();
        t_midwrite();
        check(doubles == 0, "R8 width", doubles, 0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule